// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is an eight-line general-purpose I/O port. Software accesses it through a single-cycle, memory-mapped register strobe. Each line has a stored output value and a direction bit. The pad buffers appear as three separate vectors: output value, output enable and input. Every line also has its own interrupt detector, configured by two bits:

- The kind bit chooses level or edge sensing.
- The polarity bit chooses low/falling or high/rising.

A per-line enable decides whether a detected condition reaches the interrupt. Edge events are held in a latch until software writes a one to the matching bit of the acknowledge register. Level conditions are not held; they follow the input. An optional per-line filter rejects short glitches before detection. The enabled status of all lines is available per line and as one combined interrupt.

Inputs pass through a two-flop synchronizer first. The debounce filter, when selected, then waits for a new value to persist for `DEB_COUNT` (default 4) consecutive sample ticks. A sample tick occurs once every `TICK_DIV` clocks (default 4).

Top module: `gpio_irq_port`

## Requirements
- R1: The direction register at offset 0x10 drives `padOe` directly, where bit value 1 makes the line an output. It reads back at 0x10.
- R2: The output register at offset 0x00 drives `padOut`. A read of 0x00 returns the stored output bit on output lines and the synchronized pad input on input lines.
- R3: With kind bit 0 (register 0x90), a line's status is a level condition that is not latched. Polarity bit 1 (register 0x94) flags a high input and polarity bit 0 flags a low input.
- R4: With kind bit 1, a rising edge (polarity 1) or falling edge (polarity 0) of the input sets that line's latch. The latch stays set after the input changes back.
- R5: Writing offset 0x98 clears the latch of every line whose written bit is 1. Lines written with 0 keep their latch. A read of 0x98 returns 0.
- R6: A line whose enable bit (register 0x9c) is 0 never sets its edge latch and never shows status. Setting the enable later reveals no earlier edge.
- R7: `pinStatus` and the read of 0xa0 give the enabled status. The read of 0xa4 gives the status before enabling. `irqOut` is 1 exactly when any enabled status bit is 1.
- R8: With the debounce bit set (register 0xa8), an input change lasting fewer than `DEB_COUNT` sample ticks is ignored. A change held longer is accepted.
- R9: After reset all registers are 0: every line is an input, `padOe` is 0, `irqOut` is 0 and all status is 0.
- R10: The kind, polarity, enable and debounce registers read back the value written at their own offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from `busAddr` |
| padIn | input | 8 | Pad input values |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| pinStatus | output | 8 | Enabled per-line status |
| irqOut | output | 1 | Combined interrupt |

## Verification
The properties assume that a write lasts one cycle with a stable address and data, and that `padIn` is the only source of input transitions. Apart from the debounce cases, the stimulus holds every pad vector for eight clocks, longer than the synchronizer and detection path. Configuration and acknowledge writes are issued only while the pads are steady, so that an edge and a register update never land in the same cycle. The random phase leaves debounce off and draws random kind, polarity, enable, acknowledge and pad values from a fixed seed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_DIR    = 8'h10;
  localparam logic [7:0] OFS_KIND   = 8'h90;
  localparam logic [7:0] OFS_POL    = 8'h94;
  localparam logic [7:0] OFS_ACK    = 8'h98;
  localparam logic [7:0] OFS_EN     = 8'h9c;
  localparam logic [7:0] OFS_MASKED = 8'ha0;
  localparam logic [7:0] OFS_RAW    = 8'ha4;
  localparam logic [7:0] OFS_DEB    = 8'ha8;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_DATA,
    RD_DIR,
    RD_KIND,
    RD_POL,
    RD_EN,
    RD_MASKED,
    RD_RAW,
    RD_DEB
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrKind;
    logic   wrPol;
    logic   wrAck;
    logic   wrEn;
    logic   wrDeb;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  logic doWrite;
  assign doWrite = busSel && busWr;

  always_comb begin
    strobe = '0;
    strobe.rdSel = RD_NONE;
    unique case (busAddr)
      ADDR_W'(OFS_DATA):   begin strobe.wrData = doWrite; strobe.rdSel = RD_DATA; end
      ADDR_W'(OFS_DIR):    begin strobe.wrDir  = doWrite; strobe.rdSel = RD_DIR;  end
      ADDR_W'(OFS_KIND):   begin strobe.wrKind = doWrite; strobe.rdSel = RD_KIND; end
      ADDR_W'(OFS_POL):    begin strobe.wrPol  = doWrite; strobe.rdSel = RD_POL;  end
      ADDR_W'(OFS_ACK):    begin strobe.wrAck  = doWrite; strobe.rdSel = RD_NONE; end
      ADDR_W'(OFS_EN):     begin strobe.wrEn   = doWrite; strobe.rdSel = RD_EN;   end
      ADDR_W'(OFS_MASKED): strobe.rdSel = RD_MASKED;
      ADDR_W'(OFS_RAW):    strobe.rdSel = RD_RAW;
      ADDR_W'(OFS_DEB):    begin strobe.wrDeb  = doWrite; strobe.rdSel = RD_DEB;  end
      default:             strobe.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int TICK_DIV  = 4,
  parameter int DEB_COUNT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] pinStatus,
  output logic             irqOut
);

  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CNT_W  = $clog2(DEB_COUNT + 1);

  logic [WIDTH-1:0] dataReg, dirReg, kindReg, polReg, enReg, debReg;
  logic [WIDTH-1:0] syncA, syncB, filt, filtPrev, edgeLatch;
  logic [WIDTH-1:0] riseHit, fallHit, edgeSet, levelHit, rawStatus, maskedStatus;
  logic [TICK_W-1:0] tickCnt;
  logic tick;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
      kindReg <= '0;
      polReg  <= '0;
      enReg   <= '0;
      debReg  <= '0;
    end else begin
      if (strobe.wrData) dataReg <= busWdata;
      if (strobe.wrDir)  dirReg  <= busWdata;
      if (strobe.wrKind) kindReg <= busWdata;
      if (strobe.wrPol)  polReg  <= busWdata;
      if (strobe.wrEn)   enReg   <= busWdata;
      if (strobe.wrDeb)  debReg  <= busWdata;
    end
  end

  // two-flop synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  // sample tick prescaler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (tickCnt == TICK_W'(TICK_DIV - 1)) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end
  assign tick = (tickCnt == TICK_W'(TICK_DIV - 1));

  // per-line debounce filter
  for (genvar i = 0; i < WIDTH; i++) begin : g_filt
    logic [CNT_W-1:0] holdCnt;
    logic             filtBit;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        holdCnt <= '0;
        filtBit <= 1'b0;
      end else if (!debReg[i]) begin
        holdCnt <= '0;
        filtBit <= syncB[i];
      end else if (syncB[i] == filtBit) begin
        holdCnt <= '0;
      end else if (tick) begin
        if (holdCnt == CNT_W'(DEB_COUNT - 1)) begin
          holdCnt <= '0;
          filtBit <= syncB[i];
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
    end
    assign filt[i] = filtBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) filtPrev <= '0;
    else       filtPrev <= filt;
  end

  // detection
  assign riseHit  = filt & ~filtPrev;
  assign fallHit  = ~filt & filtPrev;
  assign edgeSet  = enReg & kindReg & ((polReg & riseHit) | (~polReg & fallHit));
  assign levelHit = ~(polReg ^ filt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeLatch <= '0;
    end else begin
      edgeLatch <= ((edgeLatch & ~(strobe.wrAck ? busWdata : '0)) | edgeSet) & kindReg;
    end
  end

  assign rawStatus    = (kindReg & edgeLatch) | (~kindReg & levelHit);
  assign maskedStatus = rawStatus & enReg;
  assign pinStatus    = maskedStatus;
  assign irqOut       = |maskedStatus;
  assign padOut       = dataReg;
  assign padOe        = dirReg;

  always_comb begin
    unique case (strobe.rdSel)
      RD_DATA:   busRdata = (dataReg & dirReg) | (syncB & ~dirReg);
      RD_DIR:    busRdata = dirReg;
      RD_KIND:   busRdata = kindReg;
      RD_POL:    busRdata = polReg;
      RD_EN:     busRdata = enReg;
      RD_MASKED: busRdata = maskedStatus;
      RD_RAW:    busRdata = rawStatus;
      RD_DEB:    busRdata = debReg;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIDTH     = 8,
  parameter int TICK_DIV  = 4,
  parameter int DEB_COUNT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  pinStatus,
  output logic              irqOut
);

  ctrlStrobe_t strobe;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpio_irq_dp #(
    .WIDTH    (WIDTH),
    .TICK_DIV (TICK_DIV),
    .DEB_COUNT(DEB_COUNT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .pinStatus(pinStatus),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WIDTH-1:0]  busWdata,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  pinStatus,
  input logic              irqOut,
  input logic [WIDTH-1:0]  enReg,
  input logic [WIDTH-1:0]  rawStatus
);

  // R1
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(8'h10)) |=> (padOe == $past(busWdata)));

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == ADDR_W'(8'h00)) |=> (padOut == $past(busWdata)));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinStatus & ~enReg) == '0));

  // R7
  irq_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut == (pinStatus != '0)));

  // R7
  masked_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinStatus & ~rawStatus) == '0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .padOut   (padOut),
  .padOe    (padOe),
  .pinStatus(pinStatus),
  .irqOut   (irqOut),
  .enReg    (u_dp.enReg),
  .rawStatus(u_dp.rawStatus)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] padIn = '0;
  logic [7:0] padOut, padOe, pinStatus;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .pinStatus(pinStatus), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic setPads(input logic [7:0] v);
    @(negedge clk);
    padIn = v;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] expStatus(input logic [7:0] kind, input logic [7:0] pol,
                                           input logic [7:0] en, input logic [7:0] latch,
                                           input logic [7:0] pads);
    logic [7:0] raw;
    raw = (kind & latch) | (~kind & ~(pol ^ pads));
    return raw & en;
  endfunction

  initial begin
    logic [7:0] rd;
    logic [7:0] mKind, mPol, mEn, mLatch, mPad, nPad, v, rise, fall;
    void'($urandom(32'd4242));

    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 padOe", padOe, 8'h00);
    check("R9 irqOut", {7'b0, irqOut}, 8'h00);
    busRead(8'h90, rd); check("R9 kind reset", rd, 8'h00);
    busRead(8'ha0, rd); check("R9 masked reset", rd, 8'h00);

    // R1 direction
    busWrite(8'h10, 8'ha5);
    @(negedge clk);
    check("R1 padOe", padOe, 8'ha5);
    busRead(8'h10, rd); check("R1 dir readback", rd, 8'ha5);

    // R2 data
    busWrite(8'h00, 8'h3c);
    setPads(8'h0f);
    check("R2 padOut", padOut, 8'h3c);
    busRead(8'h00, rd); check("R2 data read mix", rd, 8'h2e);

    // R10 readback
    busWrite(8'h90, 8'h55); busRead(8'h90, rd); check("R10 kind", rd, 8'h55);
    busWrite(8'h94, 8'h96); busRead(8'h94, rd); check("R10 pol", rd, 8'h96);
    busWrite(8'h9c, 8'h69); busRead(8'h9c, rd); check("R10 en", rd, 8'h69);
    busWrite(8'ha8, 8'hc3); busRead(8'ha8, rd); check("R10 deb", rd, 8'hc3);
    busWrite(8'ha8, 8'h00);
    busRead(8'h98, rd); check("R5 ack reads zero", rd, 8'h00);

    // R3 level mode
    busWrite(8'h90, 8'h00);
    busWrite(8'h94, 8'h0f);
    busWrite(8'h9c, 8'hff);
    setPads(8'h33);
    check("R3 level status", pinStatus, 8'hc3);
    setPads(8'h00);
    check("R3 level not latched", pinStatus, 8'hf0);

    // R4 edge mode
    busWrite(8'h90, 8'hff);
    busWrite(8'h98, 8'hff);
    setPads(8'hff);
    check("R4 rising", pinStatus, 8'h0f);
    setPads(8'h00);
    check("R4 falling", pinStatus, 8'hff);
    setPads(8'hff);
    check("R4 held", pinStatus, 8'hff);

    // R5 acknowledge
    busWrite(8'h98, 8'h00);
    @(negedge clk);
    check("R5 ack zero keeps", pinStatus, 8'hff);
    busWrite(8'h98, 8'h81);
    @(negedge clk);
    check("R5 ack clears ones", pinStatus, 8'h7e);

    // R6 enable gating
    busWrite(8'h9c, 8'h0f);
    busWrite(8'h98, 8'hff);
    setPads(8'h00);
    setPads(8'hff);
    check("R6 enabled only", pinStatus, 8'h0f);
    busRead(8'ha4, rd); check("R6 raw no latch when disabled", rd, 8'h0f);
    busWrite(8'h9c, 8'hff);
    @(negedge clk);
    check("R6 no stale edge", pinStatus, 8'h0f);

    // R7 status views
    busWrite(8'h9c, 8'h03);
    busRead(8'ha0, rd); check("R7 masked read", rd, 8'h03);
    busRead(8'ha4, rd); check("R7 raw read", rd, 8'h0f);
    check("R7 irq high", {7'b0, irqOut}, 8'h01);
    busWrite(8'h98, 8'hff);
    @(negedge clk);
    check("R7 irq low", {7'b0, irqOut}, 8'h00);

    // R8 debounce: level-high on line 0
    busWrite(8'h90, 8'h00);
    busWrite(8'h94, 8'h01);
    busWrite(8'h9c, 8'h01);
    setPads(8'h00);
    busWrite(8'ha8, 8'h01);
    @(negedge clk); padIn = 8'h01;
    repeat (7) @(negedge clk);
    check("R8 short pulse during", pinStatus, 8'h00);
    padIn = 8'h00;
    repeat (30) @(negedge clk);
    check("R8 short pulse after", pinStatus, 8'h00);
    padIn = 8'h01;
    repeat (40) @(negedge clk);
    check("R8 long hold accepted", pinStatus, 8'h01);
    busWrite(8'ha8, 8'h00);
    busWrite(8'h90, 8'h00);
    busWrite(8'h94, 8'h00);
    busWrite(8'h9c, 8'h00);
    setPads(8'h00);

    // random phase (R3 R4 R5 R6 R7)
    mKind = 0; mPol = 0; mEn = 0; mLatch = 0; mPad = 0;
    for (int it = 0; it < 150; it++) begin
      v = 8'($urandom);
      case ($urandom % 8)
        0: begin busWrite(8'h90, v); mKind = v; mLatch &= v; end
        1: begin busWrite(8'h94, v); mPol = v; end
        2: begin busWrite(8'h9c, v); mEn = v; end
        3: begin busWrite(8'h98, v); mLatch &= ~v; end
        default: ;
      endcase
      nPad = 8'($urandom);
      rise = nPad & ~mPad;
      fall = ~nPad & mPad;
      mLatch |= mEn & mKind & ((mPol & rise) | (~mPol & fall));
      mPad = nPad;
      setPads(nPad);
      check("R4 R3 random status", pinStatus, expStatus(mKind, mPol, mEn, mLatch, mPad));
      check("R7 random irq", {7'b0, irqOut},
            {7'b0, (expStatus(mKind, mPol, mEn, mLatch, mPad) != 0)});
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule